// File: doc/BRIEF.md
# Trap capability register legaliser

This block holds the two capability-wide trap registers of a hart: the exception return capability (written on trap entry and by software) and the trap handler vector capability. Every write is legalised: low address bits that the hardware owns are forced to their legal values, and the tag is kept only when the legalisation did not damage the capability. The tag is dropped when the address changed on a sealed capability, when the address is not representable, or when a vectored handler table would reach past the representable region.

Representability arithmetic is not computed here. An external helper supplies it as ready-made flags. The block also serves a read view of the exception return capability that respects a 32-bit instruction alignment mode. It computes the handler target from the stored vector: the base address, or the base plus four times the cause number for interrupts in vectored mode.

Top module: `trap_cap_legaliser`

## Requirements
- R1: After reset both registers hold the root capability: tag 1, unsealed, address 0, metadata equal to the ROOT_META parameter.
- R2: A write to the exception return register always stores address bit 0 as zero.
- R3: A written tag is stored as 0 when the supplied representability flag for the legalised address is low.
- R4: A written tag is cleared when the capability is sealed and legalisation changed its address. A sealed capability whose address is left unchanged keeps its tag.
- R5: Vector address bits [1:0] are the mode field: 0 is direct and 1 is vectored. Values 2 and 3 are stored as 0 (direct), which counts as an address change for the sealing check in R4.
- R6: A vector write with legalised mode 1 stores tag 0 when the span flag (representability of base + 4 × highest cause) is low. In direct mode the span flag has no effect.
- R7: The handler target is the vector address with bits [1:0] cleared. When the stored mode is vectored and an interrupt is flagged, four times the cause number is added.
- R8: With the 32-bit alignment input high, the exception return read view shows address bit 1 as zero. The read tag is cleared if this changed the address and the stored capability is sealed or the read representability flag is low. The stored value itself is not altered.
- R9: A trap-entry write to the exception return register wins over a software write to it in the same cycle. A software write to the vector register in that cycle still takes effect.
- R10: Without a write enable, neither register changes, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_we_i | input | 1 | Software write enable |
| sw_sel_i | input | 1 | Software target: 0 exception return, 1 vector |
| sw_tag_i | input | 1 | Software write tag |
| sw_sealed_i | input | 1 | Software write sealed flag |
| sw_addr_i | input | ADDR_W | Software write address |
| sw_meta_i | input | META_W | Software write metadata |
| sw_rep_ok_i | input | 1 | Legalised software address is representable |
| sw_span_ok_i | input | 1 | Base + 4 × highest cause is representable |
| trap_we_i | input | 1 | Trap entry writes the program-counter capability |
| trap_tag_i | input | 1 | Trap entry tag |
| trap_sealed_i | input | 1 | Trap entry sealed flag |
| trap_addr_i | input | ADDR_W | Trap entry address |
| trap_meta_i | input | META_W | Trap entry metadata |
| trap_rep_ok_i | input | 1 | Legalised trap address is representable |
| ialign32_i | input | 1 | 32-bit instruction alignment mode for reads |
| rd_rep_ok_i | input | 1 | Read-legalised address is representable |
| irq_i | input | 1 | Target is for an interrupt |
| cause_i | input | CAUSE_W | Interrupt cause number |
| epc_tag_o | output | 1 | Exception return read tag |
| epc_sealed_o | output | 1 | Exception return sealed flag |
| epc_addr_o | output | ADDR_W | Exception return read address |
| epc_meta_o | output | META_W | Exception return metadata |
| vec_tag_o | output | 1 | Vector tag |
| vec_sealed_o | output | 1 | Vector sealed flag |
| vec_addr_o | output | ADDR_W | Vector address including mode |
| vec_meta_o | output | META_W | Vector metadata |
| tgt_addr_o | output | ADDR_W | Handler target address |

## Verification
The properties assume that the representability flags match the address presented in the same cycle. They also assume the cause number stays within the implemented width, so that base plus offset never wraps past the representable region the span flag vouched for. The directed tests drive each flag together with the address it describes and use cause values below the highest implemented cause. They exercise the trap-and-software collision only with the software write aimed at either register, never with both enables asserted and the select changing mid-cycle.

// File: rtl/trap_cap_pkg.sv
package trap_cap_pkg;
  typedef enum logic {
    SEL_EPC = 1'b0,
    SEL_VEC = 1'b1
  } reg_sel_e;

  localparam logic [1:0] MODE_DIRECT = 2'd0;
  localparam logic [1:0] MODE_VECT   = 2'd1;
endpackage

// File: rtl/tcap_wr_legal.sv
module tcap_wr_legal #(
  parameter int unsigned ADDR_W = 32,
  parameter bit          IS_VEC = 1'b0
) (
  input  logic              tag_i,
  input  logic              sealed_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rep_ok_i,
  input  logic              span_ok_i,
  output logic              tag_o,
  output logic [ADDR_W-1:0] addr_o
);
  import trap_cap_pkg::*;

  logic changed;
  logic span_fail;

  generate
    if (IS_VEC) begin : g_vec
      logic [1:0] mode_leg;
      assign mode_leg  = (addr_i[1:0] == MODE_VECT) ? MODE_VECT : MODE_DIRECT;
      assign addr_o    = {addr_i[ADDR_W-1:2], mode_leg};
      assign changed   = (addr_i[1:0] != mode_leg);
      assign span_fail = (mode_leg == MODE_VECT) && !span_ok_i;
    end else begin : g_epc
      logic unused_span;
      assign unused_span = span_ok_i;
      assign addr_o      = {addr_i[ADDR_W-1:1], 1'b0};
      assign changed     = addr_i[0];
      assign span_fail   = 1'b0;
    end
  endgenerate

  assign tag_o = tag_i && rep_ok_i && !(changed && sealed_i) && !span_fail;
endmodule

// File: rtl/tcap_store.sv
module tcap_store #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned META_W    = 16,
  parameter logic [META_W-1:0] ROOT_META = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              tag_i,
  input  logic              sealed_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [META_W-1:0] meta_i,
  output logic              tag_o,
  output logic              sealed_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [META_W-1:0] meta_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o    <= 1'b1;
      sealed_o <= 1'b0;
      addr_o   <= '0;
      meta_o   <= ROOT_META;
    end else if (we_i) begin
      tag_o    <= tag_i;
      sealed_o <= sealed_i;
      addr_o   <= addr_i;
      meta_o   <= meta_i;
    end
  end
endmodule

// File: rtl/tcap_rd_legal.sv
module tcap_rd_legal #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              ialign32_i,
  input  logic              rd_rep_ok_i,
  input  logic              tag_i,
  input  logic              sealed_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              tag_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic changed;
  assign changed = ialign32_i && addr_i[1];
  assign addr_o  = changed ? {addr_i[ADDR_W-1:2], 1'b0, addr_i[0]} : addr_i;
  assign tag_o   = tag_i && !(changed && (sealed_i || !rd_rep_ok_i));
endmodule

// File: rtl/tcap_vec_tgt.sv
module tcap_vec_tgt #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic [ADDR_W-1:0]  vec_addr_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [ADDR_W-1:0]  tgt_o
);
  import trap_cap_pkg::*;

  localparam int unsigned OFF_W = CAUSE_W + 2;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off;

  assign base = {vec_addr_i[ADDR_W-1:2], 2'b00};

  always_comb begin
    off = '0;
    if (irq_i && (vec_addr_i[1:0] == MODE_VECT)) off[OFF_W-1:0] = {cause_i, 2'b00};
  end

  assign tgt_o = base + off;
endmodule

// File: rtl/trap_cap_legaliser.sv
module trap_cap_legaliser #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned META_W    = 16,
  parameter int unsigned CAUSE_W   = 4,
  parameter logic [META_W-1:0] ROOT_META = 16'hA5C3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_we_i,
  input  logic               sw_sel_i,
  input  logic               sw_tag_i,
  input  logic               sw_sealed_i,
  input  logic [ADDR_W-1:0]  sw_addr_i,
  input  logic [META_W-1:0]  sw_meta_i,
  input  logic               sw_rep_ok_i,
  input  logic               sw_span_ok_i,
  input  logic               trap_we_i,
  input  logic               trap_tag_i,
  input  logic               trap_sealed_i,
  input  logic [ADDR_W-1:0]  trap_addr_i,
  input  logic [META_W-1:0]  trap_meta_i,
  input  logic               trap_rep_ok_i,
  input  logic               ialign32_i,
  input  logic               rd_rep_ok_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               epc_tag_o,
  output logic               epc_sealed_o,
  output logic [ADDR_W-1:0]  epc_addr_o,
  output logic [META_W-1:0]  epc_meta_o,
  output logic               vec_tag_o,
  output logic               vec_sealed_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic [META_W-1:0]  vec_meta_o,
  output logic [ADDR_W-1:0]  tgt_addr_o
);
  import trap_cap_pkg::*;

  // exception return path: trap entry wins over software
  logic              epc_src_tag, epc_src_sealed, epc_src_rep;
  logic [ADDR_W-1:0] epc_src_addr;
  logic [META_W-1:0] epc_src_meta;
  logic              epc_we;
  logic              epc_leg_tag;
  logic [ADDR_W-1:0] epc_leg_addr;
  logic              epc_q_tag;
  logic [ADDR_W-1:0] epc_q_addr;

  assign epc_we         = trap_we_i || (sw_we_i && (reg_sel_e'(sw_sel_i) == SEL_EPC));
  assign epc_src_tag    = trap_we_i ? trap_tag_i    : sw_tag_i;
  assign epc_src_sealed = trap_we_i ? trap_sealed_i : sw_sealed_i;
  assign epc_src_addr   = trap_we_i ? trap_addr_i   : sw_addr_i;
  assign epc_src_meta   = trap_we_i ? trap_meta_i   : sw_meta_i;
  assign epc_src_rep    = trap_we_i ? trap_rep_ok_i : sw_rep_ok_i;

  tcap_wr_legal #(.ADDR_W(ADDR_W), .IS_VEC(1'b0)) epc_wl_i (
    .tag_i    (epc_src_tag),
    .sealed_i (epc_src_sealed),
    .addr_i   (epc_src_addr),
    .rep_ok_i (epc_src_rep),
    .span_ok_i(1'b1),
    .tag_o    (epc_leg_tag),
    .addr_o   (epc_leg_addr)
  );

  tcap_store #(.ADDR_W(ADDR_W), .META_W(META_W), .ROOT_META(ROOT_META)) epc_reg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (epc_we),
    .tag_i   (epc_leg_tag),
    .sealed_i(epc_src_sealed),
    .addr_i  (epc_leg_addr),
    .meta_i  (epc_src_meta),
    .tag_o   (epc_q_tag),
    .sealed_o(epc_sealed_o),
    .addr_o  (epc_q_addr),
    .meta_o  (epc_meta_o)
  );

  tcap_rd_legal #(.ADDR_W(ADDR_W)) epc_rl_i (
    .ialign32_i (ialign32_i),
    .rd_rep_ok_i(rd_rep_ok_i),
    .tag_i      (epc_q_tag),
    .sealed_i   (epc_sealed_o),
    .addr_i     (epc_q_addr),
    .tag_o      (epc_tag_o),
    .addr_o     (epc_addr_o)
  );

  // vector path
  logic              vec_we;
  logic              vec_leg_tag;
  logic [ADDR_W-1:0] vec_leg_addr;

  assign vec_we = sw_we_i && (reg_sel_e'(sw_sel_i) == SEL_VEC);

  tcap_wr_legal #(.ADDR_W(ADDR_W), .IS_VEC(1'b1)) vec_wl_i (
    .tag_i    (sw_tag_i),
    .sealed_i (sw_sealed_i),
    .addr_i   (sw_addr_i),
    .rep_ok_i (sw_rep_ok_i),
    .span_ok_i(sw_span_ok_i),
    .tag_o    (vec_leg_tag),
    .addr_o   (vec_leg_addr)
  );

  tcap_store #(.ADDR_W(ADDR_W), .META_W(META_W), .ROOT_META(ROOT_META)) vec_reg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vec_we),
    .tag_i   (vec_leg_tag),
    .sealed_i(sw_sealed_i),
    .addr_i  (vec_leg_addr),
    .meta_i  (sw_meta_i),
    .tag_o   (vec_tag_o),
    .sealed_o(vec_sealed_o),
    .addr_o  (vec_addr_o),
    .meta_o  (vec_meta_o)
  );

  tcap_vec_tgt #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) tgt_i (
    .vec_addr_i(vec_addr_o),
    .irq_i     (irq_i),
    .cause_i   (cause_i),
    .tgt_o     (tgt_addr_o)
  );
endmodule

// File: rtl/trap_cap_checker.sv
module trap_cap_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned META_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sw_we_i,
  input logic              sw_sel_i,
  input logic              sw_sealed_i,
  input logic [ADDR_W-1:0] sw_addr_i,
  input logic              sw_span_ok_i,
  input logic              trap_we_i,
  input logic [ADDR_W-1:0] trap_addr_i,
  input logic [META_W-1:0] trap_meta_i,
  input logic              irq_i,
  input logic              epc_tag_o,
  input logic [ADDR_W-1:0] epc_addr_o,
  input logic [META_W-1:0] epc_meta_o,
  input logic              vec_tag_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [ADDR_W-1:0] tgt_addr_o
);
  // R2
  a_r2_epc_bit0_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_addr_o[0] == 1'b0);

  // R4
  a_r4_sealed_shift_drops_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && !sw_sel_i && !trap_we_i && sw_sealed_i && sw_addr_i[0]) |=> !epc_tag_o);

  // R5
  a_r5_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_addr_o[1] == 1'b0);

  // R6
  a_r6_span_drops_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && sw_sel_i && (sw_addr_i[1:0] == 2'b01) && !sw_span_ok_i) |=> !vec_tag_o);

  // R7
  a_r7_exc_target_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i |-> (tgt_addr_o == {vec_addr_o[ADDR_W-1:2], 2'b00}));

  // R9
  a_r9_trap_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_we_i && sw_we_i && !sw_sel_i) |=>
      (epc_addr_o[ADDR_W-1:2] == $past(trap_addr_i[ADDR_W-1:2])) && (epc_meta_o == $past(trap_meta_i)));

  // R10
  a_r10_vec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_we_i && sw_sel_i) |=> $stable(vec_addr_o) && $stable(vec_tag_o));
endmodule

bind trap_cap_legaliser trap_cap_checker #(.ADDR_W(ADDR_W), .META_W(META_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sw_we_i     (sw_we_i),
  .sw_sel_i    (sw_sel_i),
  .sw_sealed_i (sw_sealed_i),
  .sw_addr_i   (sw_addr_i),
  .sw_span_ok_i(sw_span_ok_i),
  .trap_we_i   (trap_we_i),
  .trap_addr_i (trap_addr_i),
  .trap_meta_i (trap_meta_i),
  .irq_i       (irq_i),
  .epc_tag_o   (epc_tag_o),
  .epc_addr_o  (epc_addr_o),
  .epc_meta_o  (epc_meta_o),
  .vec_tag_o   (vec_tag_o),
  .vec_addr_o  (vec_addr_o),
  .tgt_addr_o  (tgt_addr_o)
);

// File: tb/trap_cap_legaliser_tb_top.sv
module trap_cap_legaliser_tb_top;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned META_W  = 16;
  localparam int unsigned CAUSE_W = 4;
  localparam logic [META_W-1:0] ROOT = 16'hA5C3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_we_i = 0, sw_sel_i = 0, sw_tag_i = 0, sw_sealed_i = 0;
  logic [ADDR_W-1:0] sw_addr_i = '0;
  logic [META_W-1:0] sw_meta_i = '0;
  logic sw_rep_ok_i = 1, sw_span_ok_i = 1;
  logic trap_we_i = 0, trap_tag_i = 0, trap_sealed_i = 0;
  logic [ADDR_W-1:0] trap_addr_i = '0;
  logic [META_W-1:0] trap_meta_i = '0;
  logic trap_rep_ok_i = 1, ialign32_i = 0, rd_rep_ok_i = 1, irq_i = 0;
  logic [CAUSE_W-1:0] cause_i = '0;
  logic epc_tag_o, epc_sealed_o, vec_tag_o, vec_sealed_o;
  logic [ADDR_W-1:0] epc_addr_o, vec_addr_o, tgt_addr_o;
  logic [META_W-1:0] epc_meta_o, vec_meta_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  trap_cap_legaliser #(.ADDR_W(ADDR_W), .META_W(META_W), .CAUSE_W(CAUSE_W), .ROOT_META(ROOT)) dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic sel, input logic tag, input logic sealed,
                          input logic [ADDR_W-1:0] addr, input logic [META_W-1:0] meta,
                          input logic rep, input logic span);
    @(negedge clk_i);
    sw_we_i = 1; sw_sel_i = sel; sw_tag_i = tag; sw_sealed_i = sealed;
    sw_addr_i = addr; sw_meta_i = meta; sw_rep_ok_i = rep; sw_span_ok_i = span;
    @(negedge clk_i);
    sw_we_i = 0; sw_rep_ok_i = 1; sw_span_ok_i = 1;
  endtask

  task automatic t_reset;
    chk("R1 epc tag", epc_tag_o, 1);
    chk("R1 epc sealed", epc_sealed_o, 0);
    chk("R1 epc addr", epc_addr_o, 0);
    chk("R1 epc meta", epc_meta_o, ROOT);
    chk("R1 vec tag", vec_tag_o, 1);
    chk("R1 vec addr", vec_addr_o, 0);
    chk("R1 vec meta", vec_meta_o, ROOT);
  endtask

  task automatic t_epc_write;
    sw_write(0, 1, 0, 32'h1001, 16'h0101, 1, 1);
    chk("R2 epc addr", epc_addr_o, 32'h1000);
    chk("R2 epc tag", epc_tag_o, 1);
    chk("R2 epc meta", epc_meta_o, 16'h0101);
    sw_write(0, 1, 0, 32'h2000, 16'h0202, 0, 1);
    chk("R3 unrep tag", epc_tag_o, 0);
    sw_write(0, 1, 1, 32'h3001, 16'h0303, 1, 1);
    chk("R4 sealed shifted tag", epc_tag_o, 0);
    chk("R4 sealed shifted addr", epc_addr_o, 32'h3000);
    sw_write(0, 1, 1, 32'h3004, 16'h0303, 1, 1);
    chk("R4 sealed intact tag", epc_tag_o, 1);
    chk("R4 sealed flag", epc_sealed_o, 1);
  endtask

  task automatic t_vec_mode;
    sw_write(1, 1, 0, 32'h4003, 16'h0404, 1, 1);
    chk("R5 mode3 addr", vec_addr_o, 32'h4000);
    chk("R5 mode3 tag", vec_tag_o, 1);
    sw_write(1, 1, 1, 32'h4002, 16'h0404, 1, 1);
    chk("R5 sealed mode2 tag", vec_tag_o, 0);
    sw_write(1, 1, 1, 32'h4001, 16'h0404, 1, 1);
    chk("R5 sealed vectored tag", vec_tag_o, 1);
    chk("R5 vectored addr", vec_addr_o, 32'h4001);
    sw_write(1, 1, 0, 32'h4000, 16'h0404, 0, 1);
    chk("R3 vec unrep tag", vec_tag_o, 0);
  endtask

  task automatic t_vec_span;
    sw_write(1, 1, 0, 32'h5001, 16'h0505, 1, 0);
    chk("R6 span fail tag", vec_tag_o, 0);
    sw_write(1, 1, 0, 32'h5000, 16'h0505, 1, 0);
    chk("R6 direct ignores span", vec_tag_o, 1);
  endtask

  task automatic t_target;
    sw_write(1, 1, 0, 32'h6001, 16'h0606, 1, 1);
    irq_i = 1; cause_i = 4'd7; #1;
    chk("R7 vectored irq", tgt_addr_o, 32'h601C);
    irq_i = 0; #1;
    chk("R7 vectored exc", tgt_addr_o, 32'h6000);
    sw_write(1, 1, 0, 32'h6000, 16'h0606, 1, 1);
    irq_i = 1; cause_i = 4'd5; #1;
    chk("R7 direct irq", tgt_addr_o, 32'h6000);
    irq_i = 0;
  endtask

  task automatic t_ialign;
    sw_write(0, 1, 1, 32'h7002, 16'h0707, 1, 1);
    chk("R8 ia16 addr", epc_addr_o, 32'h7002);
    chk("R8 ia16 tag", epc_tag_o, 1);
    ialign32_i = 1; #1;
    chk("R8 ia32 addr", epc_addr_o, 32'h7000);
    chk("R8 ia32 sealed tag", epc_tag_o, 0);
    ialign32_i = 0;
    sw_write(0, 1, 0, 32'h7006, 16'h0707, 1, 1);
    ialign32_i = 1; rd_rep_ok_i = 0; #1;
    chk("R8 ia32 unrep tag", epc_tag_o, 0);
    rd_rep_ok_i = 1; #1;
    chk("R8 ia32 unsealed tag", epc_tag_o, 1);
    chk("R8 ia32 addr2", epc_addr_o, 32'h7004);
    ialign32_i = 0; #1;
    chk("R8 store intact", epc_addr_o, 32'h7006);
  endtask

  task automatic t_trap;
    @(negedge clk_i);
    trap_we_i = 1; trap_tag_i = 1; trap_sealed_i = 0; trap_addr_i = 32'h8005; trap_meta_i = 16'h1111;
    sw_we_i = 1; sw_sel_i = 0; sw_tag_i = 1; sw_sealed_i = 0; sw_addr_i = 32'h9000; sw_meta_i = 16'h2222;
    @(negedge clk_i);
    sw_we_i = 0; trap_we_i = 0;
    chk("R9 trap wins addr", epc_addr_o, 32'h8004);
    chk("R9 trap wins meta", epc_meta_o, 16'h1111);
    @(negedge clk_i);
    trap_we_i = 1; trap_addr_i = 32'h8100; trap_meta_i = 16'h3333;
    sw_we_i = 1; sw_sel_i = 1; sw_addr_i = 32'h9100; sw_meta_i = 16'h4444;
    @(negedge clk_i);
    sw_we_i = 0; trap_we_i = 0;
    chk("R9 epc from trap", epc_addr_o, 32'h8100);
    chk("R9 vec from sw", vec_addr_o, 32'h9100);
    chk("R9 vec meta", vec_meta_o, 16'h4444);
  endtask

  task automatic t_hold;
    @(negedge clk_i);
    sw_addr_i = 32'hDEAD_BEEF; sw_meta_i = 16'hFFFF; sw_tag_i = 0; sw_sel_i = 1;
    trap_addr_i = 32'hCAFE_0000; trap_tag_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R10 vec hold", vec_addr_o, 32'h9100);
    chk("R10 epc hold", epc_addr_o, 32'h8100);
    chk("R10 epc tag hold", epc_tag_o, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_epc_write();
    t_vec_mode();
    t_vec_span();
    t_target();
    t_ialign();
    t_trap();
    t_hold();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule